// File: doc/BRIEF.md
# UART Receive Character Queue with Idle Time-out

This block is the receive-side store of a 16550-style UART channel. It sits between the receive shift register and the host read port. Each incoming character arrives as one byte plus three error flags: parity, framing and break. The block keeps the byte and its flags together and hands them back in arrival order. The host sees the oldest character on the holding-register read path, and that character's flags on three line-status bits.

Two modes are supported. In queue mode the store holds up to 16 characters. The receive-data interrupt rises once the fill reaches a selectable trigger level. An idle time-out interrupt flushes small remainders: it fires when characters wait and no new character has arrived for four character lengths plus twelve bit times. In single mode the store holds exactly one character, and the interrupt rises as soon as that character is present. A one-cycle clear empties the store and resets the time-out.

Top module: `uart_rx_queue`

## Requirements
- R1: In queue mode up to DEPTH (16) characters are held, each with its 8 data bits and 3 flags, and they are returned in arrival order; `fill` reports the number held.
- R2: `err_tags` shows the flags of the oldest held character as {break, framing, parity} on bits 2, 1, 0. It is zero when empty. After a read it shows the next character's flags from the following cycle on, together with its byte on `rd_data`.
- R3: With `fifo_en` low, the store holds at most one character.
- R4: `data_ready` is high exactly when at least one character is held.
- R5: In queue mode `rx_int` is high when `rx_int_en` is set and the fill is at least the trigger level that `trig_sel` selects: 0 gives 1, 1 gives 4, 2 gives 8, 3 gives 14.
- R6: In single mode `rx_int` is high when `rx_int_en` is set and a character is held. With `rx_int_en` low, neither interrupt is raised.
- R7: In queue mode with `rx_int_en` set, `tout_int` rises after (4·(5+`wlen_sel`)+12)·16 `tick16` pulses with data held and no write or read. `wlen_sel` 0..3 means 5..8 data bits.
- R8: An accepted write or a read restarts the time-out count. Emptying the store clears it, and `tout_int` is never high while empty.
- R9: A write while full, with no read in the same cycle, is discarded and sets `overrun`. The flag stays set until a cycle with `lsr_rd` high.
- R10: `clr_fifo` empties the store and restarts the time-out in one cycle. A write in that cycle is discarded.
- R11: A write and a read in the same cycle on a full store are both performed; nothing is lost and `overrun` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | 16x bit-rate enable pulse |
| fifo_en | input | 1 | 1 = queue mode, 0 = single-character mode |
| clr_fifo | input | 1 | Clear pulse |
| trig_sel | input | 2 | Trigger level select |
| wlen_sel | input | 2 | Data bits per character select |
| rx_int_en | input | 1 | Receive interrupt enable |
| wr_en | input | 1 | Character arrives from the shift register |
| wr_data | input | 8 | Received byte |
| wr_perr | input | 1 | Parity error flag of the arriving character |
| wr_ferr | input | 1 | Framing error flag of the arriving character |
| wr_brk | input | 1 | Break flag of the arriving character |
| rd_en | input | 1 | Host reads the holding register |
| lsr_rd | input | 1 | Host reads line status |
| rd_data | output | 8 | Oldest held byte, zero when empty |
| err_tags | output | 3 | Flags of the oldest byte |
| data_ready | output | 1 | At least one character held |
| overrun | output | 1 | Sticky overrun flag |
| rx_int | output | 1 | Receive-data interrupt |
| tout_int | output | 1 | Idle time-out interrupt |
| fill | output | 5 | Characters held |

## Verification
Every cycle, the assertions check the fill bound and its one-step changes, the result of a read, and that a clear empties the store. They also check that overrun is set on a discarded write and held until a status read, and that both interrupts are silent when disabled or empty. Only the bench's scenarios can show that bytes and flags leave in arrival order and stay paired, that the time-out fires on exactly the right tick for each word length, the trigger thresholds, and the capacity limit of single mode.

// File: rtl/uart_rx_queue.sv
module uart_rx_queue #(
  parameter int DEPTH         = 16,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       fifo_en,
  input  logic       clr_fifo,
  input  logic [1:0] trig_sel,
  input  logic [1:0] wlen_sel,
  input  logic       rx_int_en,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_perr,
  input  logic       wr_ferr,
  input  logic       wr_brk,
  input  logic       rd_en,
  input  logic       lsr_rd,
  output logic [7:0] rd_data,
  output logic [2:0] err_tags,
  output logic       data_ready,
  output logic       overrun,
  output logic       rx_int,
  output logic       tout_int,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int AW      = $clog2(DEPTH);
  localparam int CW      = $clog2(DEPTH + 1);
  localparam int MAX_LIM = (4 * 8 + 12) * TICKS_PER_BIT;
  localparam int TW      = $clog2(MAX_LIM + 1);

  logic [10:0]   mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cap, trig;
  logic [TW-1:0] tcnt, lim;
  logic          ovr, full, rd_ok, wr_ok, wr_drop, empty;

  assign empty   = (cnt == '0);
  assign cap     = fifo_en ? CW'(DEPTH) : CW'(1);
  assign full    = (cnt >= cap);
  assign rd_ok   = rd_en && !empty;
  assign wr_ok   = wr_en && (!full || rd_ok);
  assign wr_drop = wr_en && full && !rd_ok;
  assign lim     = TW'(((32'(wlen_sel) + 5) * 4 + 12) * TICKS_PER_BIT);

  always_comb begin
    case (trig_sel)
      2'd0:    trig = CW'(1);
      2'd1:    trig = CW'(4);
      2'd2:    trig = CW'(8);
      default: trig = CW'(14);
    endcase
  end

  always_ff @(posedge clk)
    if (wr_ok && !clr_fifo) mem[wptr] <= {wr_brk, wr_ferr, wr_perr, wr_data};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (clr_fifo) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) rptr <= rptr + 1'b1;
      cnt <= cnt + CW'(wr_ok) - CW'(rd_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  tcnt <= '0;
    else if (clr_fifo || wr_ok || rd_ok || empty) tcnt <= '0;
    else if (tick16 && tcnt < lim)               tcnt <= tcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr <= 1'b0;
    else        ovr <= (ovr && !lsr_rd) || (wr_drop && !clr_fifo);
  end

  assign rd_data    = empty ? 8'h00 : mem[rptr][7:0];
  assign err_tags   = empty ? 3'b000 : mem[rptr][10:8];
  assign data_ready = !empty;
  assign overrun    = ovr;
  assign fill       = cnt;
  assign rx_int     = rx_int_en && (fifo_en ? (cnt >= trig) : !empty);
  assign tout_int   = rx_int_en && fifo_en && !empty && (tcnt >= lim);
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       fifo_en,
  input logic       clr_fifo,
  input logic       rx_int_en,
  input logic       wr_en,
  input logic       rd_en,
  input logic       lsr_rd,
  input logic       data_ready,
  input logic       overrun,
  input logic       rx_int,
  input logic       tout_int,
  input logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int CW = $clog2(DEPTH + 1);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH)); // R1
  AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_fifo |=> (fill == $past(fill) || fill == $past(fill) + 1'b1 || fill + 1'b1 == $past(fill))); // R1
  AST_READ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && data_ready && !wr_en && !clr_fifo) |=> (fill + 1'b1 == $past(fill))); // R1
  AST_DR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> (fill != '0)); // R4
  AST_INT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_int_en |-> (!rx_int && !tout_int)); // R6
  AST_TOUT_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    tout_int |-> (data_ready && fifo_en)); // R8
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !clr_fifo && fifo_en && fill == CW'(DEPTH)) |=> overrun); // R9
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !lsr_rd) |=> overrun); // R9
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fifo |=> (fill == '0 && !data_ready && !tout_int)); // R10
endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .clr_fifo(clr_fifo),
  .rx_int_en(rx_int_en), .wr_en(wr_en), .rd_en(rd_en), .lsr_rd(lsr_rd),
  .data_ready(data_ready), .overrun(overrun), .rx_int(rx_int),
  .tout_int(tout_int), .fill(fill)
);

// File: tb/uart_rx_queue_tb.sv
`timescale 1ns/1ps
module uart_rx_queue_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick16 = 0, fifo_en = 1, clr_fifo = 0, rx_int_en = 1;
  logic [1:0] trig_sel = 0, wlen_sel = 0;
  logic wr_en = 0, wr_perr = 0, wr_ferr = 0, wr_brk = 0, rd_en = 0, lsr_rd = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic [2:0] err_tags;
  logic data_ready, overrun, rx_int, tout_int;
  logic [4:0] fill;

  int total = 0, bad = 0;
  bit done = 0;
  logic [10:0] q[$];
  bit movr = 0;
  int mt = 0;

  uart_rx_queue u_dut (.*);

  always #2.5 clk = ~clk;

  function automatic int trig_of(input logic [1:0] s);
    case (s) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction
  function automatic int lim_of(input logic [1:0] w);
    return ((4 * (5 + int'(w))) + 12) * 16;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [10:0] h;
    int n;
    n = q.size();
    h = (n > 0) ? q[0] : 11'h0;
    check("R1 fill", fill, n);
    check("R1 rd_data", rd_data, h[7:0]);
    check("R2 err_tags", err_tags, h[10:8]);
    check("R4 data_ready", data_ready, n > 0);
    check(fifo_en ? "R5 rx_int" : "R6 rx_int", rx_int,
          rx_int_en && (fifo_en ? (n >= trig_of(trig_sel)) : (n > 0)));
    check("R7 tout_int", tout_int,
          rx_int_en && fifo_en && n > 0 && mt >= lim_of(wlen_sel));
    check("R9 overrun", overrun, movr);
  endtask

  task automatic cyc(input bit w, input logic [10:0] v, input bit r, input bit lr, input bit c);
    int cap, n;
    bit full, rdok, wrok, drop;
    wr_en = w; {wr_brk, wr_ferr, wr_perr, wr_data} = v;
    rd_en = r; lsr_rd = lr; clr_fifo = c;
    n = q.size();
    cap = fifo_en ? 16 : 1;
    full = n >= cap;
    rdok = r && n > 0;
    wrok = w && (!full || rdok);
    drop = w && full && !rdok;
    @(posedge clk);
    if (c) begin
      q.delete(); mt = 0; movr = movr && !lr;
    end else begin
      movr = (movr && !lr) || drop;
      if (rdok) void'(q.pop_front());
      if (wrok) q.push_back(v);
      if (wrok || rdok || n == 0) mt = 0;
      else if (tick16 && mt < lim_of(wlen_sel)) mt++;
    end
    #1;
    compare();
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    #(200000 * 5);
    bad++; total++;
    $display("FAIL watchdog expired");
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #12; rst_n = 1; #1;
    compare();                                 // reset state R1 R4

    // R1 R9: fill to 16, overflow, order preserved, overrun sticky
    for (int i = 0; i < 16; i++) cyc(1, 11'(i * 37 + (i % 8) * 256), 0, 0, 0);
    check("R1 full", fill, 16);
    cyc(1, 11'h7ff, 0, 0, 0);
    check("R9 overrun set", overrun, 1);
    idle(3);
    check("R9 overrun held", overrun, 1);
    // R11: full, simultaneous read+write
    cyc(1, 11'h5a5, 1, 1, 0);
    check("R11 fill", fill, 16);
    check("R9 overrun cleared", overrun, 0);
    for (int i = 0; i < 16; i++) cyc(0, 0, 1, 0, 0);   // R2 checked each cycle
    check("R11 last byte kept", fill, 0);

    // R5 trigger levels
    for (int s = 0; s < 4; s++) begin
      trig_sel = 2'(s);
      for (int i = 0; i < trig_of(2'(s)) - 1; i++) cyc(1, 11'(s + i), 0, 0, 0);
      check("R5 below trigger", rx_int, 0);
      cyc(1, 11'h100, 0, 0, 0);
      check("R5 at trigger", rx_int, 1);
      cyc(0, 0, 0, 0, 1);
      check("R10 cleared", fill, 0);
    end

    // R3 R6: single mode
    fifo_en = 0;
    cyc(1, 11'h612, 0, 0, 0);
    check("R6 rx_int single", rx_int, 1);
    cyc(1, 11'h033, 0, 0, 0);
    check("R3 capacity one", fill, 1);
    check("R3 first kept", rd_data, 8'h12);
    check("R2 tags single", err_tags, 3'b110);
    rx_int_en = 0; #1;
    check("R6 gated", rx_int, 0);
    rx_int_en = 1;
    cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 1);
    fifo_en = 1; trig_sel = 3;

    // R7 R8: time-out per word length
    tick16 = 1;
    for (int w = 0; w < 4; w++) begin
      wlen_sel = 2'(w);
      cyc(1, 11'h0c0 + 11'(w), 0, 0, 0);
      idle(lim_of(2'(w)) - 1);
      check("R7 not yet", tout_int, 0);
      idle(1);
      check("R7 fires", tout_int, 1);
      cyc(0, 0, 1, 0, 0);
      check("R8 clears on empty", tout_int, 0);
    end
    wlen_sel = 0;
    cyc(1, 11'h011, 0, 0, 0);
    cyc(1, 11'h022, 0, 0, 0);
    idle(300);
    cyc(0, 0, 1, 0, 0);                           // R8 read restarts
    idle(lim_of(0) - 1);
    check("R8 restart by read", tout_int, 0);
    idle(1);
    check("R8 fires after restart", tout_int, 1);
    cyc(1, 11'h044, 0, 0, 1);                      // R10 write during clear dropped
    check("R10 clear drops write", fill, 0);
    check("R10 tout cleared", tout_int, 0);

    // random phase, model checked every cycle
    for (int b = 0; b < 6; b++) begin
      cyc(0, 0, 0, 1, 1);
      fifo_en = (b != 2);
      trig_sel = 2'($urandom_range(0, 3));
      wlen_sel = 2'($urandom_range(0, 3));
      tick16 = b[0];
      for (int i = 0; i < 2000; i++)
        cyc($urandom_range(0, 99) < 55, 11'($urandom), $urandom_range(0, 99) < 40,
            $urandom_range(0, 99) < 5, $urandom_range(0, 999) < 3);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule